// File: doc/BRIEF.md
# Peak-to-Peak Trigger Detector with Decay

This block watches a stream of unsigned ADC samples and decides when a real signal event is present. While enabled, it keeps a running highest and lowest value of the accepted samples. It raises a trigger flag once the distance between them, the peak-to-peak span, has stayed at or above a programmed minimum for a programmed number of accepted samples in a row. After it rises, the flag stays high until the enable input is taken low.

Extremes from an old burst would otherwise hold the span open forever. To stop that, the tracked high and low are pulled toward each other by a programmed step once every programmed number of accepted samples. The pull never moves either extreme past the sample that arrives on that step. A capture controller drives the enable input: it raises enable to arm a new detection, reads the trigger flag, and lowers enable to clear the block.

Top module: `ptp_trigger`

## Requirements
- R1: Out of reset, and in the cycle after any cycle with `enable_i` low, `fire_o` is 0 and all tracking state is cleared.
- R2: The first accepted sample after enable rises loads both the tracked high and the tracked low with that sample, so the span for that sample is 0.
- R3: A sample is accepted only in a cycle where both `enable_i` and `sample_vld_i` are high. In any other cycle `sample_i` has no effect on any state.
- R4: For each accepted sample, the new high is the larger of the (possibly decayed) old high and the sample. The new low is the smaller of the (possibly decayed) old low and the sample. The span is new high minus new low, and it counts as above threshold when it is greater than or equal to `span_min_i`.
- R5: `fire_o` rises in the cycle after the accepted sample that completes `hold_cnt_i` consecutive above-threshold samples. A `hold_cnt_i` of 0 behaves as 1.
- R6: Any accepted sample whose span is below `span_min_i` resets the consecutive count to zero.
- R7: Once `fire_o` is high, it stays high for as long as `enable_i` stays high.
- R8: With `leak_period_i` = P > 0, a decay step happens on every P-th accepted sample since enable rose, counting the first. On a decay step, the old high is lowered by `leak_step_i` (floored at 0) and the old low is raised by it (capped at full scale) before the sample is merged, so neither extreme crosses that sample.
- R9: A `leak_period_i` of 0 is a legal setting and disables decay completely.
- R10: After enable falls and rises again, detection starts afresh, and the next accepted sample is treated as a first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Arms detection. Low clears all state |
| sample_i | input | DATA_W (10) | Unsigned ADC sample |
| sample_vld_i | input | 1 | Sample qualifier |
| span_min_i | input | DATA_W (10) | Minimum span that counts as above threshold |
| hold_cnt_i | input | CNT_W (16) | Consecutive above-threshold samples needed to fire |
| leak_step_i | input | DATA_W (10) | Amount each decay step moves the extremes |
| leak_period_i | input | CNT_W (16) | Accepted samples between decay steps, 0 disables |
| fire_o | output | 1 | Sticky trigger flag |

## Verification
Without decay the span can only grow, so a below-threshold sample can never follow an above-threshold one. The hardest condition to reach from the ports is therefore a consecutive run that is broken part way. The stimulus reaches it by programming a short decay period with a large step and then sending samples that first open the span and then sit near its middle. This lets the decay shrink the span back under the threshold before the hold count completes. The clamp at the current sample is reached the same way, with samples placed just inside the decayed extremes, and the same sequence is replayed with a period of 0 to show that decay is truly off.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
   localparam int unsigned DEF_DATA_W = 10;
   localparam int unsigned DEF_CNT_W  = 16;

   // Per-cycle control derived at the top and fanned out to the sub-blocks
   typedef struct packed {
      logic take;   // sample accepted this cycle
      logic first;  // first accepted sample since enable rose
      logic leak;   // decay step applies to this sample
   } step_ctl_t;
endpackage

// File: rtl/ptp_leak_timer.sv
module ptp_leak_timer #(
   parameter int unsigned CNT_W   = ptp_pkg::DEF_CNT_W,
   parameter bit          LEAK_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             take_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             tick_o
);
   localparam int unsigned SUM_W = CNT_W + 1;

   if (CNT_W < 1) begin : g_bad_w
      $error("ptp_leak_timer: CNT_W must be at least 1");
   end

   if (LEAK_EN) begin : g_timer
      logic [CNT_W-1:0] cnt_q;
      logic [SUM_W-1:0] cnt_inc;
      logic             due;

      always_comb begin
         cnt_inc = {1'b0, cnt_q} + SUM_W'(1);
         due     = (period_i != '0) && (cnt_inc >= {1'b0, period_i});
         tick_o  = take_i && due;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q <= '0;
         end else if (clear_i) begin
            cnt_q <= '0;
         end else if (take_i) begin
            if (due || period_i == '0) cnt_q <= '0;
            else                       cnt_q <= cnt_inc[CNT_W-1:0];
         end
      end

      // R8: the count never reaches the period while decay is on
      a_r8_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (take_i && !clear_i && $stable(period_i) && period_i != '0)
            |=> (cnt_q < period_i));
   end else begin : g_no_timer
      assign tick_o = 1'b0;
   end

   // R9: a zero period never produces a decay step
   a_r9_zero_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_i == '0) |-> !tick_o);
endmodule

// File: rtl/ptp_peak_track.sv
module ptp_peak_track
   import ptp_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter bit          LEAK_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  step_ctl_t         ctl_i,
   input  logic [DATA_W-1:0] sample_i,
   input  logic [DATA_W-1:0] step_i,
   output logic [DATA_W-1:0] span_nxt_o
);
   localparam int unsigned          SUM_W = DATA_W + 1;
   localparam logic [DATA_W-1:0]    FULL  = '1;

   if (DATA_W < 2) begin : g_bad_w
      $error("ptp_peak_track: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] hi_q, lo_q;
   logic [DATA_W-1:0] hi_base, lo_base, hi_nxt, lo_nxt;

   if (LEAK_EN) begin : g_leak
      logic [DATA_W-1:0] hi_dec, lo_inc;
      logic [SUM_W-1:0]  lo_sum;
      always_comb begin
         hi_dec  = (hi_q > step_i) ? (hi_q - step_i) : '0;
         lo_sum  = {1'b0, lo_q} + {1'b0, step_i};
         lo_inc  = lo_sum[DATA_W] ? FULL : lo_sum[DATA_W-1:0];
         hi_base = ctl_i.leak ? hi_dec : hi_q;
         lo_base = ctl_i.leak ? lo_inc : lo_q;
      end
   end else begin : g_plain
      assign hi_base = hi_q;
      assign lo_base = lo_q;
   end

   // Merge the sample; decayed extremes are clamped by the sample itself
   always_comb begin
      if (ctl_i.first) begin
         hi_nxt = sample_i;
         lo_nxt = sample_i;
      end else begin
         hi_nxt = (sample_i > hi_base) ? sample_i : hi_base;
         lo_nxt = (sample_i < lo_base) ? sample_i : lo_base;
      end
      span_nxt_o = hi_nxt - lo_nxt;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (clear_i) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (ctl_i.take) begin
         hi_q <= hi_nxt;
         lo_q <= lo_nxt;
      end
   end

   // R4: the tracked high never drops below the tracked low
   a_r4_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_q >= lo_q);

   // R8: an accepted sample always lies between the stored extremes
   a_r8_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_i.take && !clear_i) |=> (hi_q >= $past(sample_i) && lo_q <= $past(sample_i)));

   // R3: nothing moves without an accepted sample
   a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctl_i.take && !clear_i) |=> ($stable(hi_q) && $stable(lo_q)));

   // R2: a first sample collapses the span
   a_r2_first_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_i.take && ctl_i.first && !clear_i) |=> (hi_q == lo_q));
endmodule

// File: rtl/ptp_run_gate.sv
module ptp_run_gate #(
   parameter int unsigned DATA_W = ptp_pkg::DEF_DATA_W,
   parameter int unsigned CNT_W  = ptp_pkg::DEF_CNT_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              take_i,
   input  logic [DATA_W-1:0] span_i,
   input  logic [DATA_W-1:0] span_min_i,
   input  logic [CNT_W-1:0]  hold_i,
   output logic              fire_o
);
   localparam logic [CNT_W-1:0] RUN_MAX = '1;
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [CNT_W-1:0] run_q, run_inc, need;
   logic             above, fire_q;

   always_comb begin
      above   = (span_i >= span_min_i);
      run_inc = (run_q == RUN_MAX) ? run_q : (run_q + ONE);
      need    = (hold_i == '0) ? ONE : hold_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= '0;
         fire_q <= 1'b0;
      end else if (clear_i) begin
         run_q  <= '0;
         fire_q <= 1'b0;
      end else if (take_i) begin
         run_q <= above ? run_inc : '0;
         if (above && run_inc >= need) fire_q <= 1'b1;
      end
   end

   assign fire_o = fire_q;

   // R6: a below-threshold sample breaks the run
   a_r6_run_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && !clear_i && span_i < span_min_i) |=> (run_q == '0));

   // R7: the flag is sticky while not cleared
   a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_q && !clear_i) |=> fire_q);

   // R5: the flag only rises on an accepted above-threshold sample
   a_r5_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fire_q) |-> ($past(take_i) && $past(span_i) >= $past(span_min_i)));
endmodule

// File: rtl/ptp_trigger.sv
module ptp_trigger
   import ptp_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned CNT_W   = DEF_CNT_W,
   parameter bit          LEAK_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [DATA_W-1:0] sample_i,
   input  logic              sample_vld_i,
   input  logic [DATA_W-1:0] span_min_i,
   input  logic [CNT_W-1:0]  hold_cnt_i,
   input  logic [DATA_W-1:0] leak_step_i,
   input  logic [CNT_W-1:0]  leak_period_i,
   output logic              fire_o
);
   if (DATA_W < 2 || CNT_W < 1) begin : g_bad_cfg
      $error("ptp_trigger: illegal width parameters");
   end

   logic              primed_q, clear, tick;
   step_ctl_t         ctl;
   logic [DATA_W-1:0] span_nxt;

   assign clear = !enable_i;

   always_comb begin
      ctl.take  = enable_i && sample_vld_i;
      ctl.first = !primed_q;
      ctl.leak  = tick;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       primed_q <= 1'b0;
      else if (clear)    primed_q <= 1'b0;
      else if (ctl.take) primed_q <= 1'b1;
   end

   ptp_leak_timer #(.CNT_W(CNT_W), .LEAK_EN(LEAK_EN)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (clear),
      .take_i   (ctl.take),
      .period_i (leak_period_i),
      .tick_o   (tick)
   );

   ptp_peak_track #(.DATA_W(DATA_W), .LEAK_EN(LEAK_EN)) u_track (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear),
      .ctl_i      (ctl),
      .sample_i   (sample_i),
      .step_i     (leak_step_i),
      .span_nxt_o (span_nxt)
   );

   ptp_run_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear),
      .take_i     (ctl.take),
      .span_i     (span_nxt),
      .span_min_i (span_min_i),
      .hold_i     (hold_cnt_i),
      .fire_o     (fire_o)
   );

   // R1: disabling clears the flag by the next cycle
   a_r1_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> !fire_o);

   // R10: after a disabled cycle the next accepted sample is a first sample
   a_r10_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> !primed_q);
endmodule

// File: tb/ptp_trigger_tb.sv
module ptp_trigger_tb;
   localparam int DW = 10;
   localparam int CW = 16;
   localparam int FULL = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [DW-1:0] smp = '0;
   logic          vld = 1'b0;
   logic [DW-1:0] thr = '0;
   logic [CW-1:0] hold = '0;
   logic [DW-1:0] step = '0;
   logic [CW-1:0] per = '0;
   logic          fire;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   // Bench model state
   bit m_pr, m_fire;
   int m_hi, m_lo, m_run, m_pc;

   always #2 clk = ~clk;

   ptp_trigger u_dut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .sample_i(smp),
      .sample_vld_i(vld), .span_min_i(thr), .hold_cnt_i(hold),
      .leak_step_i(step), .leak_period_i(per), .fire_o(fire)
   );

   task automatic check(input string tag, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s fire_o actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      m_pr = 0; m_fire = 0; m_hi = 0; m_lo = 0; m_run = 0; m_pc = 0;
   endtask

   // Driver: applies one cycle of stimulus and queues the expected flag
   task automatic drv(input int d, input bit v, input bit e, input string tag);
      bit tk;
      int hb, lb, need;
      @(negedge clk);
      en = e; smp = DW'(d); vld = v;
      if (!e) model_clear();
      else if (v) begin
         tk = (per != 0) && (m_pc + 1 >= int'(per));
         m_pc = (tk || per == 0) ? 0 : m_pc + 1;
         if (!m_pr) begin
            m_hi = d; m_lo = d; m_pr = 1;
         end else begin
            hb = m_hi; lb = m_lo;
            if (tk) begin
               hb = (hb > int'(step)) ? hb - int'(step) : 0;
               lb = (lb + int'(step) > FULL) ? FULL : lb + int'(step);
            end
            m_hi = (d > hb) ? d : hb;
            m_lo = (d < lb) ? d : lb;
         end
         need = (hold == 0) ? 1 : int'(hold);
         if (m_hi - m_lo >= int'(thr)) begin
            m_run++;
            if (m_run >= need) m_fire = 1;
         end else m_run = 0;
      end
      exp_q.push_back(m_fire);
      tag_q.push_back(tag);
   endtask

   // Monitor: pops one expectation per clock, sampled after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) check(tag_q.pop_front(), fire, exp_q.pop_front());
      end
   end

   task automatic cfg(input int t, input int h, input int s, input int p);
      @(negedge clk);
      thr = DW'(t); hold = CW'(h); step = DW'(s); per = CW'(p);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      model_clear();
      repeat (4) @(negedge clk);
      #1 check("R1 reset", fire, 1'b0);
      rst_n = 1'b1;
      drv(0, 0, 0, "R1");

      // R2/R4/R5: span builds to exactly the threshold, hold of 3
      cfg(100, 3, 0, 0);
      drv(500, 1, 1, "R2");
      drv(550, 1, 1, "R4");
      drv(600, 1, 1, "R4 inclusive");
      drv(600, 1, 1, "R5");
      drv(600, 1, 1, "R5 fires");
      @(posedge clk); #1 check("R5 direct", fire, 1'b1);
      // R7: sticky while enabled
      drv(550, 1, 1, "R7");
      drv(0, 0, 1, "R7");
      // R1: disable clears
      drv(550, 1, 0, "R1 disable");
      @(posedge clk); #1 check("R1 direct", fire, 1'b0);

      // R3: invalid garbage must not widen the span
      cfg(300, 1, 0, 0);
      drv(500, 1, 1, "R10 rearm");
      drv(520, 1, 1, "R3");
      drv(0, 0, 1, "R3 ignored");
      drv(1023, 0, 1, "R3 ignored");
      drv(510, 1, 1, "R3");
      @(posedge clk); #1 check("R3 direct", fire, 1'b0);
      drv(0, 1, 0, "R1");

      // R2: thr 0 fires on a lone first sample, hold 0 treated as 1
      cfg(0, 0, 0, 0);
      drv(777, 1, 1, "R2 first");
      drv(0, 1, 0, "R1");

      // R6/R8: decay breaks the run
      cfg(200, 3, 50, 1);
      drv(500, 1, 1, "R8");
      drv(700, 1, 1, "R8");
      drv(700, 1, 1, "R6 run break");
      drv(600, 1, 1, "R6");
      drv(900, 1, 1, "R8");
      drv(300, 1, 1, "R8");
      drv(600, 1, 1, "R8");
      drv(0, 1, 0, "R1");

      // R8 vs R9: same sequence, decay on then off
      cfg(150, 1, 100, 1);
      drv(500, 1, 1, "R8 clamp");
      drv(650, 1, 1, "R8 clamp");
      @(posedge clk); #1 check("R8 direct", fire, 1'b0);
      drv(0, 1, 0, "R1");
      cfg(150, 1, 100, 0);
      drv(500, 1, 1, "R9");
      drv(650, 1, 1, "R9 no decay");
      @(posedge clk); #1 check("R9 direct", fire, 1'b1);
      drv(0, 1, 0, "R1");

      // R8: period 3, saturation near the rails
      cfg(900, 2, 200, 3);
      drv(1000, 1, 1, "R8");
      drv(20, 1, 1, "R8");
      drv(1020, 1, 1, "R8 rail");
      drv(10, 1, 1, "R8");
      drv(1023, 1, 1, "R8");
      drv(0, 1, 1, "R8");
      drv(0, 1, 0, "R1");

      // Randomised patterns against the model
      for (int r = 0; r < 12; r++) begin
         cfg($urandom_range(50, 700), $urandom_range(0, 6),
             $urandom_range(0, 120), $urandom_range(0, 5));
         for (int i = 0; i < 120; i++)
            drv($urandom_range(0, FULL), ($urandom_range(0, 3) != 0), 1'b1, "R4 random");
         drv(0, 0, 0, "R10 random");
      end

      repeat (3) @(posedge clk);
      #1;
      finish_run();
   end
endmodule